// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block keeps the exception state of a small in-order core and decides, every cycle, whether fetch has to be redirected. It holds a status word, a cause register (an exception-code field plus the pending-interrupt bits), the exception PC, the trap vector base and a faulting-address register. The pipeline presents the current PC, the sequential next PC and any synchronous exception. The block answers with the PC that fetch should use next and a one-cycle trap-taken pulse.

Interrupt lines set and clear pending bits inside the cause register. A pending interrupt is taken when it is enabled by the mask field of the status word and the global trap-enable bit is set. An inter-processor interrupt sets its own pending bit and starts the core. A synchronous exception that arrives while traps are disabled is unrecoverable: the block raises an error flag and stops the core instead of vectoring.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, cause, exception PC, vector base and faulting address read zero. The run and error flags are low. The status word reads 0x000000A0 (supervisor bit 5 and supervisor-64-bit bit 7 set).
- R2: A trap is considered only while run is high. An interrupt is taken when (cause[15:8] & status[23:16]) is nonzero and trap-enable (status bit 0) is set. An exception (exc_valid_i) is taken when trap-enable is set.
- R3: On any taken trap, status bit 0 clears, supervisor bit 5 sets, and previous-supervisor bit 4 takes the value bit 5 had before the trap.
- R4: On a taken trap only cause[4:0] changes. It becomes 16 for an interrupt or exc_code_i for an exception. The pending bits cause[15:8] are kept.
- R5: While a trap is taken, next_pc_o equals the vector base, which is written through evec_we_i. At the following edge the exception PC captures pc_i and the faulting-address register captures bad_addr_i. With no trap, next_pc_o equals seq_pc_i.
- R6: An exception arriving while run is high and trap-enable is clear is not taken. Instead error_o sets and run clears, and no exception register changes. While error_o is high, run cannot be set again.
- R7: ipi_i sets pending bit cause[13] (line 5) and sets run at the next edge.
- R8: A status write keeps only the implemented bits: 0 trap-enable, 1 FPU enable, 2 vector enable, 3 compressed enable, 4 previous-supervisor, 5 supervisor, 6 user-64, 7 supervisor-64, 8 translation enable, and 23:16 interrupt mask. Bits of disabled features are forced to zero. With the default parameters (vector and compressed disabled), writing all ones reads back 0x00FF01F3.
- R9: xlen_o is 64 when the active mode's 64-bit bit is set (bit 7 if bit 5 is set, else bit 6), otherwise 32.
- R10: An interrupt wins over a simultaneous exception. A taken trap wins over a status write in the same cycle, and the write is dropped.
- R11: irq_set_i sets pending bits and irq_clr_i clears them at the next edge. A set wins over a clear on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| pc_i | input | PC_W | PC of the instruction in flight |
| seq_pc_i | input | PC_W | sequential next PC |
| exc_valid_i | input | 1 | synchronous exception present |
| exc_code_i | input | 5 | exception code |
| bad_addr_i | input | PC_W | faulting address from the memory unit |
| irq_set_i | input | 8 | pending-bit set strobes |
| irq_clr_i | input | 8 | pending-bit clear strobes |
| ipi_i | input | 1 | inter-processor interrupt request |
| sr_we_i | input | 1 | status write enable |
| sr_wdata_i | input | 32 | status write data |
| evec_we_i | input | 1 | vector base write enable |
| evec_wdata_i | input | PC_W | vector base write data |
| next_pc_o | output | PC_W | PC for fetch to use next |
| trap_take_o | output | 1 | a trap is taken this cycle |
| error_o | output | 1 | fatal trap error (sticky) |
| run_o | output | 1 | core running |
| sr_o | output | 32 | status word |
| cause_o | output | 32 | cause register |
| epc_o | output | PC_W | exception PC |
| evec_o | output | PC_W | vector base |
| bad_addr_o | output | PC_W | faulting-address register |
| xlen_o | output | 7 | effective register width (32 or 64) |

## Verification
The bench checks that a pending interrupt blocked by the mask, by a clear trap-enable or by a stopped core is not taken. A design that skips any of these gates would vector early. It takes a trap from user mode and checks the previous-supervisor bit: a design that copies the bit after forcing supervisor mode would report 1 there. It checks that a trap keeps the pending bits and drops a status write made in the same cycle. It checks that an exception with traps disabled sets the error flag and leaves the exception PC alone, so a design that vectors anyway or overwrites state is caught. The bench also writes all ones to the status word, so a design that leaks unimplemented or feature-gated bits shows the wrong read-back.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;
  localparam int SR_W     = 32;
  localparam int NIRQ     = 8;
  localparam int CODE_W   = 5;
  localparam int SR_ET    = 0;
  localparam int SR_EF    = 1;
  localparam int SR_EV    = 2;
  localparam int SR_EC    = 3;
  localparam int SR_PS    = 4;
  localparam int SR_S     = 5;
  localparam int SR_UX    = 6;
  localparam int SR_SX    = 7;
  localparam int SR_VM    = 8;
  localparam int SR_IM_LO = 16;
  localparam int CS_PEND_LO = 8;
  localparam int IPI_LINE   = 5;
  localparam logic [CODE_W-1:0] CODE_IRQ = 5'd16;

  function automatic logic [SR_W-1:0] sr_legal(bit en64, bit fpu, bit rvc, bit vec);
    logic [SR_W-1:0] m;
    m = '0;
    m[SR_ET] = 1'b1;
    m[SR_EF] = fpu;
    m[SR_EV] = vec;
    m[SR_EC] = rvc;
    m[SR_PS] = 1'b1;
    m[SR_S]  = 1'b1;
    m[SR_UX] = en64;
    m[SR_SX] = en64;
    m[SR_VM] = 1'b1;
    m[SR_IM_LO +: NIRQ] = '1;
    return m;
  endfunction
endpackage

// File: rtl/trap_ctrl_status.sv
module trap_ctrl_status
  import trap_ctrl_pkg::*;
#(
  parameter bit EN_64  = 1'b1,
  parameter bit EN_FPU = 1'b1,
  parameter bit EN_RVC = 1'b0,
  parameter bit EN_VEC = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_i,
  input  logic            we_i,
  input  logic [SR_W-1:0] wdata_i,
  output logic [SR_W-1:0] sr_o
);
  localparam logic [SR_W-1:0] LEGAL = sr_legal(EN_64, EN_FPU, EN_RVC, EN_VEC);
  localparam logic [SR_W-1:0] RST_SR =
    ((SR_W'(1) << SR_S) | (SR_W'(1) << SR_SX)) & LEGAL;

  logic [SR_W-1:0] sr_q, sr_d, trap_sr;

  always_comb begin
    trap_sr        = sr_q;
    trap_sr[SR_ET] = 1'b0;
    trap_sr[SR_S]  = 1'b1;
    trap_sr[SR_PS] = sr_q[SR_S];
  end

  always_comb begin
    sr_d = sr_q;
    if (trap_i)    sr_d = trap_sr & LEGAL;
    else if (we_i) sr_d = wdata_i & LEGAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= RST_SR;
    else         sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/trap_ctrl_cause.sv
module trap_ctrl_cause
  import trap_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [NIRQ-1:0]   set_i,
  input  logic [NIRQ-1:0]   clr_i,
  output logic [NIRQ-1:0]   pend_o,
  output logic [SR_W-1:0]   cause_o
);
  logic [NIRQ-1:0]   pend_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      code_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | set_i;
      if (trap_i) code_q <= code_i;
    end
  end

  always_comb begin
    cause_o = '0;
    cause_o[CODE_W-1:0] = code_q;
    cause_o[CS_PEND_LO +: NIRQ] = pend_q;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/trap_ctrl_arb.sv
module trap_ctrl_arb
  import trap_ctrl_pkg::*;
(
  input  logic              run_i,
  input  logic              et_i,
  input  logic [NIRQ-1:0]   im_i,
  input  logic [NIRQ-1:0]   pend_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  output logic              take_o,
  output logic              fatal_o,
  output logic [CODE_W-1:0] code_o
);
  logic irq_take, exc_take;

  assign irq_take = run_i && et_i && |(pend_i & im_i);
  assign exc_take = run_i && et_i && exc_valid_i;
  assign fatal_o  = run_i && !et_i && exc_valid_i;
  assign take_o   = irq_take || exc_take;
  // interrupt sampled ahead of the instruction's own exception
  assign code_o   = irq_take ? CODE_IRQ : exc_code_i;
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_ctrl_pkg::*;
#(
  parameter int PC_W   = 64,
  parameter bit EN_64  = 1'b1,
  parameter bit EN_FPU = 1'b1,
  parameter bit EN_RVC = 1'b0,
  parameter bit EN_VEC = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] seq_pc_i,
  input  logic            exc_valid_i,
  input  logic [4:0]      exc_code_i,
  input  logic [PC_W-1:0] bad_addr_i,
  input  logic [7:0]      irq_set_i,
  input  logic [7:0]      irq_clr_i,
  input  logic            ipi_i,
  input  logic            sr_we_i,
  input  logic [31:0]     sr_wdata_i,
  input  logic            evec_we_i,
  input  logic [PC_W-1:0] evec_wdata_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            trap_take_o,
  output logic            error_o,
  output logic            run_o,
  output logic [31:0]     sr_o,
  output logic [31:0]     cause_o,
  output logic [PC_W-1:0] epc_o,
  output logic [PC_W-1:0] evec_o,
  output logic [PC_W-1:0] bad_addr_o,
  output logic [6:0]      xlen_o
);
  logic              take, fatal;
  logic [CODE_W-1:0] code;
  logic [NIRQ-1:0]   pend, set_all;
  logic              run_q, err_q;
  logic [PC_W-1:0]   epc_q, evec_q, bad_q;

  always_comb begin
    set_all = irq_set_i;
    set_all[IPI_LINE] = irq_set_i[IPI_LINE] | ipi_i;
  end

  trap_ctrl_arb i_arb (
    .run_i       (run_q),
    .et_i        (sr_o[SR_ET]),
    .im_i        (sr_o[SR_IM_LO +: NIRQ]),
    .pend_i      (pend),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .take_o      (take),
    .fatal_o     (fatal),
    .code_o      (code)
  );

  trap_ctrl_status #(
    .EN_64(EN_64), .EN_FPU(EN_FPU), .EN_RVC(EN_RVC), .EN_VEC(EN_VEC)
  ) i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trap_i  (take),
    .we_i    (sr_we_i),
    .wdata_i (sr_wdata_i),
    .sr_o    (sr_o)
  );

  trap_ctrl_cause i_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trap_i  (take),
    .code_i  (code),
    .set_i   (set_all),
    .clr_i   (irq_clr_i),
    .pend_o  (pend),
    .cause_o (cause_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      err_q  <= 1'b0;
      epc_q  <= '0;
      evec_q <= '0;
      bad_q  <= '0;
    end else begin
      if (fatal) begin
        err_q <= 1'b1;
        run_q <= 1'b0;
      end else if (ipi_i && !err_q) begin
        run_q <= 1'b1;
      end
      if (take) begin
        epc_q <= pc_i;
        bad_q <= bad_addr_i;
      end
      if (evec_we_i) evec_q <= evec_wdata_i;
    end
  end

  assign next_pc_o   = take ? evec_q : seq_pc_i;
  assign trap_take_o = take;
  assign error_o     = err_q;
  assign run_o       = run_q;
  assign epc_o       = epc_q;
  assign evec_o      = evec_q;
  assign bad_addr_o  = bad_q;
  assign xlen_o      = (sr_o[SR_S] ? sr_o[SR_SX] : sr_o[SR_UX]) ? 7'd64 : 7'd32;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
  import trap_ctrl_pkg::*;
#(
  parameter int PC_W = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] pc_i,
  input logic            exc_valid_i,
  input logic [7:0]      irq_set_i,
  input logic [7:0]      irq_clr_i,
  input logic            ipi_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic            trap_take_o,
  input logic            error_o,
  input logic            run_o,
  input logic [31:0]     sr_o,
  input logic [31:0]     cause_o,
  input logic [PC_W-1:0] epc_o,
  input logic [PC_W-1:0] evec_o
);
  // R3
  et_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o |=> !sr_o[SR_ET] && sr_o[SR_S]);
  // R3
  prev_sup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o |=> sr_o[SR_PS] == $past(sr_o[SR_S]));
  // R5
  epc_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o |=> epc_o == $past(pc_i));
  // R5
  vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o |-> next_pc_o == evec_o);
  // R4
  pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o && !ipi_i && irq_set_i == 8'h0 && irq_clr_i == 8'h0
    |=> cause_o[15:8] == $past(cause_o[15:8]));
  // R2
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o |-> run_o && sr_o[SR_ET]);
  // R2
  irq_need_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_take_o && !exc_valid_i |-> (cause_o[15:8] & sr_o[23:16]) != 8'h0);
  // R6
  fatal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i && run_o && !sr_o[SR_ET] |=> error_o && !run_o);
  // R6
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !run_o && !trap_take_o);
  // R7
  ipi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_i && !error_o && !(exc_valid_i && run_o && !sr_o[SR_ET])
    |=> run_o && cause_o[CS_PEND_LO + IPI_LINE]);
  // R8
  reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o[31:24] == 8'h0 && sr_o[15:9] == 7'h0);
endmodule

bind trap_ctrl trap_ctrl_chk #(.PC_W(PC_W)) i_trap_ctrl_chk (.*);

// File: tb/test_trap_ctrl.sv
`timescale 1ns/1ps
module test_trap_ctrl;
  localparam int PC_W = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [PC_W-1:0] pc_i = '0, seq_pc_i = '0, bad_addr_i = '0, evec_wdata_i = '0;
  logic            exc_valid_i = 1'b0, ipi_i = 1'b0, sr_we_i = 1'b0, evec_we_i = 1'b0;
  logic [4:0]      exc_code_i = '0;
  logic [7:0]      irq_set_i = '0, irq_clr_i = '0;
  logic [31:0]     sr_wdata_i = '0;
  logic [PC_W-1:0] next_pc_o, epc_o, evec_o, bad_addr_o;
  logic            trap_take_o, error_o, run_o;
  logic [31:0]     sr_o, cause_o;
  logic [6:0]      xlen_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  trap_ctrl #(.PC_W(PC_W)) i_trap_ctrl (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one edge, return 1 ns after it
  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr_sr(logic [31:0] v);
    sr_we_i = 1'b1; sr_wdata_i = v;
    step();
    sr_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sr", sr_o, 32'h0000_00A0);
    chk("R1 cause", cause_o, 0);
    chk("R1 epc", epc_o, 0);
    chk("R1 evec", evec_o, 0);
    chk("R1 bad", bad_addr_o, 0);
    chk("R1 run", run_o, 0);
    chk("R1 err", error_o, 0);
    chk("R9 xlen reset", xlen_o, 64);
  endtask

  task automatic t_norun();
    exc_valid_i = 1'b1; exc_code_i = 5'd2; seq_pc_i = 64'h40; pc_i = 64'h44;
    #1;
    chk("R2 no take halted", trap_take_o, 0);
    chk("R5 seq pc", next_pc_o, 64'h40);
    step();
    exc_valid_i = 1'b0;
    chk("R2 epc untouched", epc_o, 0);
    chk("R6 no error halted", error_o, 0);
  endtask

  task automatic t_ipi();
    ipi_i = 1'b1;
    step();
    ipi_i = 1'b0;
    chk("R7 run", run_o, 1);
    chk("R7 pending", cause_o, 32'h0000_2000);
    irq_clr_i = 8'h20;
    step();
    irq_clr_i = 8'h0;
    chk("R11 clear", cause_o, 0);
    irq_set_i = 8'h01; irq_clr_i = 8'h01;
    step();
    irq_set_i = 8'h0; irq_clr_i = 8'h0;
    chk("R11 set wins", cause_o, 32'h0000_0100);
    irq_clr_i = 8'h01;
    step();
    irq_clr_i = 8'h0;
  endtask

  task automatic t_sr();
    wr_sr(32'hFFFF_FFFF);
    chk("R8 mask", sr_o, 32'h00FF_01F3);
    wr_sr(32'h0000_0041);
    chk("R9 user64", xlen_o, 64);
    wr_sr(32'h0000_0001);
    chk("R9 user32", xlen_o, 32);
    wr_sr(32'h0000_0060);
    chk("R9 sup32", xlen_o, 32);
    evec_we_i = 1'b1; evec_wdata_i = 64'h1000;
    step();
    evec_we_i = 1'b0;
    chk("R5 evec", evec_o, 64'h1000);
  endtask

  task automatic t_irq();
    wr_sr(32'h0000_00A1);
    irq_set_i = 8'h04;
    step();
    irq_set_i = 8'h0;
    chk("R2 masked", trap_take_o, 0);
    wr_sr(32'h0004_00A0);
    chk("R2 et clear", trap_take_o, 0);
    pc_i = 64'h300; bad_addr_i = 64'h55; seq_pc_i = 64'h304;
    wr_sr(32'h0004_00A1);
    chk("R2 irq take", trap_take_o, 1);
    chk("R5 vector", next_pc_o, 64'h1000);
    step();
    chk("R3 status", sr_o, 32'h0004_00B0);
    chk("R4 cause irq", cause_o, 32'h0000_0410);
    chk("R5 epc", epc_o, 64'h300);
    chk("R5 bad", bad_addr_o, 64'h55);
    chk("R2 no retake", trap_take_o, 0);
    irq_clr_i = 8'h04;
    step();
    irq_clr_i = 8'h0;
  endtask

  task automatic t_exc();
    wr_sr(32'h0000_0041);
    exc_valid_i = 1'b1; exc_code_i = 5'd5; pc_i = 64'h2468; bad_addr_i = 64'hDEAD;
    #1;
    chk("R2 exc take", trap_take_o, 1);
    chk("R5 exc vector", next_pc_o, 64'h1000);
    step();
    exc_valid_i = 1'b0;
    chk("R3 from user", sr_o, 32'h0000_0060);
    chk("R4 cause exc", cause_o, 32'h0000_0005);
    chk("R5 epc exc", epc_o, 64'h2468);
    chk("R5 bad exc", bad_addr_o, 64'hDEAD);
    chk("R9 after trap", xlen_o, 32);
  endtask

  task automatic t_prio();
    irq_set_i = 8'h02;
    wr_sr(32'h0002_00A1);
    irq_set_i = 8'h0;
    exc_valid_i = 1'b1; exc_code_i = 5'd3; pc_i = 64'h700;
    sr_we_i = 1'b1; sr_wdata_i = 32'h0000_0001;
    #1;
    chk("R10 take", trap_take_o, 1);
    step();
    exc_valid_i = 1'b0; sr_we_i = 1'b0;
    chk("R10 write dropped", sr_o, 32'h0002_00B0);
    chk("R10 irq code wins", cause_o, 32'h0000_0210);
    irq_clr_i = 8'h02;
    step();
    irq_clr_i = 8'h0;
  endtask

  task automatic t_fatal();
    exc_valid_i = 1'b1; exc_code_i = 5'd7; pc_i = 64'h900; seq_pc_i = 64'h904;
    #1;
    chk("R6 no take", trap_take_o, 0);
    chk("R6 seq pc", next_pc_o, 64'h904);
    step();
    exc_valid_i = 1'b0;
    chk("R6 error", error_o, 1);
    chk("R6 halted", run_o, 0);
    chk("R6 epc kept", epc_o, 64'h700);
    chk("R6 cause kept", cause_o, 32'h0000_0010);
    ipi_i = 1'b1;
    step();
    ipi_i = 1'b0;
    chk("R6 stays halted", run_o, 0);
  endtask

  initial begin
    #22 rst_ni = 1'b1;
    #1;
    t_reset();
    t_norun();
    t_ipi();
    t_sr();
    t_irq();
    t_exc();
    t_prio();
    t_fatal();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule